// File: doc/BRIEF.md
# Pixel Two-Port Output Splitter

This block sits behind a triple-channel sampler and receives one sample per channel on every pixel clock. It sends those samples to two output ports per channel, called A and B. Alongside the data it produces three more outputs. The first is an update strobe that marks when the port contents are valid for the downstream logic. The second is a drive-enable for port B, which stands in for a tri-state pad. The third is a copy of the line-start pulse, delayed so that it stays aligned with the data.

There are three operating modes:
- **Single-port**: every sample goes to port A, and port B is left undriven.
- **Dual-port interleaved**: consecutive pixels of a line go to alternate ports, and only one port changes per pixel.
- **Dual-port paired**: pixels are grouped in twos, and both ports change together once per pair.

A swap option makes the first pixel of each line land on port B instead of port A. Pixel position within a line is counted from a one-cycle line-start pulse, which is assumed to be synchronous already. The mode inputs are captured only in the line-start cycle, so a mode change never splits a line.

Top module: `pix_port_demux`

## Requirements
- R1: While reset is asserted, and afterwards until the first sample reaches the outputs, `port_a` and `port_b` are zero and `port_b_oe`, `dclk_en` and `line_start_out` are 0. The active mode after reset is single-port.
- R2: In single-port mode (`cfg_dual`=0), every input sample appears on `port_a` after the fixed latency. `port_b` is zero and `port_b_oe` is 0. `cfg_pair` and `cfg_swap` have no effect in this mode.
- R3: `dclk_en` is 1 for every pixel in single-port mode. In either dual-port mode it is 1 only for the second pixel of each pair (odd position, counting the line-start pixel as position 0), so it runs at half the pixel rate.
- R4: In dual-port interleaved mode (`cfg_dual`=1, `cfg_pair`=0, `cfg_swap`=0), the pixel at an even position is written to port A and the pixel at an odd position to port B. The other port keeps its previous value.
- R5: With `cfg_swap`=1 in either dual-port mode, the port assignment is reversed: even positions go to port B and odd positions to port A.
- R6: In dual-port paired mode (`cfg_pair`=1), the even-position pixel is held internally. Both ports are written together when the odd-position pixel arrives, with the even pixel on A and the odd pixel on B (reversed by R5). Both ports hold their values on even positions.
- R7: A line-start pulse resets the position to 0. If a paired-mode line ends on an even position, the held pixel never reaches either port.
- R8: The `cfg_*` inputs are sampled only in the cycle where `line_start`=1. Changes at any other time have no effect on the outputs.
- R9: Data, `dclk_en`, `port_b_oe` and `line_start_out` all share the same latency of 1+`EXTRA_STAGES` clocks, measured from the input cycle.
- R10: `port_b_oe` is 1 exactly for the pixels handled in a dual-port mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle pulse marking the first pixel of a line |
| cfg_dual | input | 1 | 1 = dual-port modes, 0 = single-port |
| cfg_pair | input | 1 | 1 = paired updates, 0 = interleaved |
| cfg_swap | input | 1 | 1 = first pixel of a line goes to port B |
| pix_in | input | PIX_W*NUM_CH | One sample per channel; channel c occupies bits [c*PIX_W +: PIX_W] |
| port_a | output | PIX_W*NUM_CH | Port A data for all channels |
| port_b | output | PIX_W*NUM_CH | Port B data for all channels |
| port_b_oe | output | 1 | Drive-enable for port B |
| dclk_en | output | 1 | Output update strobe (data clock enable) |
| line_start_out | output | 1 | Line-start pulse aligned with the data |

## Verification
A position counter that is wrong by one would swap the A and B contents and shift `dclk_en` by one pixel. This shows up within two pixels of any line start, including lines with an odd length. A mode register that loads outside the line-start cycle would change `port_b_oe` or the routing in the middle of a line, one latency period after the change. A staging register that is not held, or one that is written at the wrong moment, would put a pixel on a port in the wrong pair, or on an even position, within one pair time.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
   typedef struct packed {
      logic dual;
      logic pair;
      logic swap;
   } pdm_mode_t;
endpackage

// File: rtl/pdm_seq.sv
// Line-position and mode sequencer: turns the active mode and pixel
// parity into write controls for the channel lanes.
module pdm_seq
   import pdm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      line_start,
   input  pdm_mode_t cfg,
   output pdm_mode_t mode_eff,
   output pdm_mode_t mode_reg,
   output logic      par_eff,
   output logic      wr_a,
   output logic      wr_b,
   output logic      a_from_stg,
   output logic      b_from_stg,
   output logic      stg_en,
   output logic      clr_b
);
   pdm_mode_t mode_q;
   logic      par_q;
   logic      to_b;

   always_comb begin
      mode_eff   = line_start ? cfg : mode_q;
      par_eff    = line_start ? 1'b0 : par_q;
      to_b       = par_eff ^ mode_eff.swap;
      wr_a       = 1'b0;
      wr_b       = 1'b0;
      a_from_stg = 1'b0;
      b_from_stg = 1'b0;
      stg_en     = 1'b0;
      clr_b      = 1'b0;
      if (!mode_eff.dual) begin
         wr_a  = 1'b1;
         clr_b = 1'b1;
      end else if (!mode_eff.pair) begin
         wr_a = ~to_b;
         wr_b = to_b;
      end else if (!par_eff) begin
         stg_en = 1'b1;
      end else begin
         wr_a       = 1'b1;
         wr_b       = 1'b1;
         a_from_stg = ~mode_eff.swap;
         b_from_stg = mode_eff.swap;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         par_q  <= 1'b0;
      end else begin
         mode_q <= mode_eff;
         par_q  <= ~par_eff;
      end
   end

   assign mode_reg = mode_q;
endmodule

// File: rtl/pdm_lane.sv
// One colour channel: staging register plus the two port registers.
module pdm_lane #(
   parameter int PIX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] pix,
   input  logic             wr_a,
   input  logic             wr_b,
   input  logic             a_from_stg,
   input  logic             b_from_stg,
   input  logic             stg_en,
   input  logic             clr_b,
   output logic [PIX_W-1:0] a_q,
   output logic [PIX_W-1:0] b_q
);
   logic [PIX_W-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= '0;
         a_q   <= '0;
         b_q   <= '0;
      end else begin
         if (stg_en) stg_q <= pix;
         if (wr_a)   a_q   <= a_from_stg ? stg_q : pix;
         if (clr_b)     b_q <= '0;
         else if (wr_b) b_q <= b_from_stg ? stg_q : pix;
      end
   end
endmodule

// File: rtl/pdm_pipe.sv
// Uniform retiming for the whole output bundle; STAGES may be zero.
module pdm_pipe #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES == 0) begin : g_wire
         assign q = d;
      end else begin : g_regs
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= d;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pix_port_demux.sv
module pix_port_demux
   import pdm_pkg::*;
#(
   parameter int PIX_W        = 8,
   parameter int NUM_CH       = 3,
   parameter int EXTRA_STAGES = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    line_start,
   input  logic                    cfg_dual,
   input  logic                    cfg_pair,
   input  logic                    cfg_swap,
   input  logic [PIX_W*NUM_CH-1:0] pix_in,
   output logic [PIX_W*NUM_CH-1:0] port_a,
   output logic [PIX_W*NUM_CH-1:0] port_b,
   output logic                    port_b_oe,
   output logic                    dclk_en,
   output logic                    line_start_out
);
   localparam int BUS_W    = PIX_W * NUM_CH;
   localparam int BUNDLE_W = 2 * BUS_W + 3;

   generate
      if (PIX_W < 1)        begin : g_bad_w  $error("PIX_W must be at least 1");        end
      if (NUM_CH < 1)       begin : g_bad_ch $error("NUM_CH must be at least 1");       end
      if (EXTRA_STAGES < 0) begin : g_bad_st $error("EXTRA_STAGES must not be negative"); end
   endgenerate

   pdm_mode_t cfg_in, mode_eff, mode_reg;
   logic par_eff, wr_a, wr_b, a_from_stg, b_from_stg, stg_en, clr_b;
   logic [BUS_W-1:0] a_core, b_core;
   logic oe_q, dclk_q, sync_q, pair_q;

   assign cfg_in = '{dual: cfg_dual, pair: cfg_pair, swap: cfg_swap};
   assign pair_q = mode_reg.pair;

   pdm_seq i_seq (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .cfg(cfg_in),
      .mode_eff(mode_eff), .mode_reg(mode_reg), .par_eff(par_eff),
      .wr_a(wr_a), .wr_b(wr_b), .a_from_stg(a_from_stg), .b_from_stg(b_from_stg),
      .stg_en(stg_en), .clr_b(clr_b)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
         pdm_lane #(.PIX_W(PIX_W)) i_lane (
            .clk(clk), .rst_n(rst_n), .pix(pix_in[c*PIX_W +: PIX_W]),
            .wr_a(wr_a), .wr_b(wr_b), .a_from_stg(a_from_stg), .b_from_stg(b_from_stg),
            .stg_en(stg_en), .clr_b(clr_b),
            .a_q(a_core[c*PIX_W +: PIX_W]), .b_q(b_core[c*PIX_W +: PIX_W])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q   <= 1'b0;
         dclk_q <= 1'b0;
         sync_q <= 1'b0;
      end else begin
         oe_q   <= mode_eff.dual;
         dclk_q <= ~mode_eff.dual | par_eff;
         sync_q <= line_start;
      end
   end

   pdm_pipe #(.WIDTH(BUNDLE_W), .STAGES(EXTRA_STAGES)) i_pipe (
      .clk(clk), .rst_n(rst_n),
      .d({a_core, b_core, oe_q, dclk_q, sync_q}),
      .q({port_a, port_b, port_b_oe, dclk_en, line_start_out})
   );
endmodule

// File: rtl/pdm_checker.sv
module pdm_checker #(
   parameter int BUS_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             line_start,
   input logic             port_b_oe,
   input logic [BUS_W-1:0] port_b,
   input logic             oe_q,
   input logic             dclk_q,
   input logic             sync_q,
   input logic             pair_q,
   input logic [BUS_W-1:0] a_core,
   input logic [BUS_W-1:0] b_core
);
   AST_B_QUIET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      !port_b_oe |-> port_b == '0); // R2

   AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      sync_q == $past(line_start)); // R9

   AST_DCLK_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q && $past(oe_q) && !sync_q) |-> dclk_q != $past(dclk_q)); // R3

   AST_MODE_AT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start |=> $stable(oe_q)); // R8

   AST_PAIR_JOINT: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_q && oe_q && !dclk_q) |-> ($stable(a_core) && $stable(b_core))); // R6

   AST_INTERLEAVE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q && !pair_q) |-> ($stable(a_core) || $stable(b_core))); // R4
endmodule

bind pix_port_demux pdm_checker #(.BUS_W(BUS_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .line_start(line_start),
   .port_b_oe(port_b_oe), .port_b(port_b),
   .oe_q(oe_q), .dclk_q(dclk_q), .sync_q(sync_q), .pair_q(pair_q),
   .a_core(a_core), .b_core(b_core)
);

// File: tb/test_pix_port_demux.sv
`timescale 1ns/1ps
module test_pix_port_demux;
   localparam int PW    = 8;
   localparam int NC    = 3;
   localparam int EXTRA = 1;
   localparam int LAT   = 1 + EXTRA;
   localparam int BW    = PW * NC;
   localparam int HMAX  = 1024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_start = 1'b0, cfg_dual = 1'b0, cfg_pair = 1'b0, cfg_swap = 1'b0;
   logic [BW-1:0] pix_in = '0;
   logic [BW-1:0] port_a, port_b;
   logic port_b_oe, dclk_en, line_start_out;

   always #5 clk = ~clk;

   pix_port_demux #(.PIX_W(PW), .NUM_CH(NC), .EXTRA_STAGES(EXTRA)) i_pix_port_demux (
      .clk(clk), .rst_n(rst_n), .line_start(line_start),
      .cfg_dual(cfg_dual), .cfg_pair(cfg_pair), .cfg_swap(cfg_swap),
      .pix_in(pix_in), .port_a(port_a), .port_b(port_b),
      .port_b_oe(port_b_oe), .dclk_en(dclk_en), .line_start_out(line_start_out)
   );

   int tests = 0, fails = 0, ncyc = 0;
   bit done = 1'b0;

   logic [BW-1:0] h_a [HMAX];
   logic [BW-1:0] h_b [HMAX];
   logic          h_oe [HMAX];
   logic          h_dclk [HMAX];
   logic          h_sync [HMAX];
   string         h_tag [HMAX];

   logic m_dual = 1'b0, m_pair = 1'b0, m_swap = 1'b0, m_par = 1'b0;
   logic [BW-1:0] m_a = '0, m_b = '0, m_stg = '0;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, ncyc);
      end
   endtask

   function automatic logic [BW-1:0] pixv(int n);
      logic [BW-1:0] v;
      for (int ch = 0; ch < NC; ch++) v[ch*PW +: PW] = 8'((n * 29 + ch * 83 + 7) & 255);
      return v;
   endfunction

   // Called at a falling edge: check outputs, drive next pixel, update model.
   task automatic step(logic s, logic d, logic p, logic w);
      int idx;
      logic e_dual, e_pair, e_swap, e_par;
      string tag;
      idx = ncyc - LAT;
      if (idx < 0) begin
         chk("R1", "port_a", 32'(port_a), 0);
         chk("R1", "port_b", 32'(port_b), 0);
         chk("R1", "oe", 32'(port_b_oe), 0);
         chk("R1", "dclk", 32'(dclk_en), 0);
         chk("R1", "sync", 32'(line_start_out), 0);
      end else begin
         chk(h_tag[idx], "port_a", 32'(port_a), 32'(h_a[idx]));
         chk(h_tag[idx], "port_b", 32'(port_b), 32'(h_b[idx]));
         chk("R10", "oe", 32'(port_b_oe), 32'(h_oe[idx]));
         chk("R3", "dclk", 32'(dclk_en), 32'(h_dclk[idx]));
         chk("R9", "sync", 32'(line_start_out), 32'(h_sync[idx]));
      end
      line_start = s; cfg_dual = d; cfg_pair = p; cfg_swap = w;
      pix_in = pixv(ncyc);
      e_dual = s ? d : m_dual;
      e_pair = s ? p : m_pair;
      e_swap = s ? w : m_swap;
      e_par  = s ? 1'b0 : m_par;
      tag = !e_dual ? "R2" : (e_pair ? "R6" : (e_swap ? "R5" : "R4"));
      if (e_dual && e_pair && e_swap) tag = "R5";
      if (s && m_dual && m_pair && m_par) tag = "R7";
      if (!s && {d, p, w} != {m_dual, m_pair, m_swap}) tag = "R8";
      if (!e_dual) begin
         m_a = pix_in; m_b = '0;
      end else if (!e_pair) begin
         if (e_par ^ e_swap) m_b = pix_in; else m_a = pix_in;
      end else if (!e_par) begin
         m_stg = pix_in;
      end else if (e_swap) begin
         m_a = pix_in; m_b = m_stg;
      end else begin
         m_a = m_stg; m_b = pix_in;
      end
      h_a[ncyc] = m_a; h_b[ncyc] = m_b; h_oe[ncyc] = e_dual;
      h_dclk[ncyc] = !e_dual || e_par; h_sync[ncyc] = s; h_tag[ncyc] = tag;
      m_dual = e_dual; m_pair = e_pair; m_swap = e_swap; m_par = !e_par;
      ncyc++;
      @(negedge clk);
   endtask

   initial begin
      int lens [4] = '{5, 6, 7, 4};
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "reset port_a", 32'(port_a), 0);
      chk("R1", "reset port_b", 32'(port_b), 0);
      chk("R1", "reset oe", 32'(port_b_oe), 0);
      chk("R1", "reset dclk", 32'(dclk_en), 0);
      rst_n = 1'b1;
      // R8: mode inputs set before any line start must not take effect
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, 1'b1);
      for (int pass = 0; pass < 2; pass++) begin
         for (int k = 0; k < 8; k++) begin
            for (int li = 0; li < 4; li++) begin
               for (int p = 0; p < lens[li]; p++) begin
                  int c;
                  c = (pass == 1 && p >= 2) ? ((k + 3) % 8) : k;
                  step(p == 0, c[2], c[1], c[0]);
               end
            end
         end
      end
      for (int i = 0; i < LAT + 2; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule